// File: doc/BRIEF.md
# Flash In-System Programming Command Engine

This block turns the contents of a small group of programming registers into operations on two on-chip program-store banks: a large main bank, 64 KB at full size, and a small loader bank, 4 KB at full size. An 8-bit control byte picks the bank and carries two strobe bits and a 4-bit operation code. A 16-bit target address comes from a high byte and a low byte, and a data byte supplies write data. The block holds a behavioural model of both banks. Erase fills the whole selected bank with FFh. Program combines the old byte with the new data by AND, as flash cells only move from 1 to 0. Read returns the byte at the target address.

Software loads the registers and then opens the programming window. The block models that window as a single-cycle `exec_i` pulse, which is honoured only while `isp_en_i` is high. A legal command raises `busy_o` for a fixed number of cycles. Erase takes a parameterised number of cycles more than program and read. When the command completes, `done_o` pulses for one cycle. Any other bit combination does not touch the banks and raises `err_o`.

The bank sizes are parameters. The main bank decodes the low `MAIN_AW` address bits and the loader bank decodes the low `LDR_AW` bits. At full size these are 16 and 12. The default build uses smaller values so that the model stays small.

Top module: `isp_cmd_engine`

## Requirements
- R1: Control byte fields: bit 6 is the bank (0 main, 1 loader), bit 5 is output enable, bit 4 is chip enable, and bits 3:0 are the operation code. Bit 7 has no effect.
- R2: Erase is code 0010 with output enable 1 and chip enable 0. It sets every byte of the selected bank to FFh, ignores address and data, and leaves the other bank unchanged.
- R3: Program is code 0001 with output enable 1 and chip enable 0. The byte at the target address becomes its old value AND `wdata_i`.
- R4: Read is code 0000 with output enable 0 and chip enable 0. `rdata_o` holds the addressed byte from the cycle `done_o` is high until the next read completes. A read changes no stored byte.
- R5: The main bank uses address bits MAIN_AW-1:0 and the loader bank uses bits LDR_AW-1:0 of {addr_hi_i, addr_lo_i}. Higher bits are ignored, so addresses that differ only there reach the same byte.
- R6: An accepted command with any other combination of code, output enable and chip enable changes no bank and raises no `busy_o`. It sets `err_o` from the next cycle. An accepted legal command clears `err_o`.
- R7: An `exec_i` pulse while `isp_en_i` is low is ignored: no busy, `err_o` unchanged, no bank change.
- R8: `busy_o` rises in the cycle after an accepted legal command. It stays high for PROG_CYC cycles for program or read, and for PROG_CYC+ERASE_EXTRA cycles for erase. `done_o` is high for exactly the one cycle after `busy_o` falls.
- R9: An `exec_i` pulse while `busy_o` is high is ignored and has no effect on the banks.
- R10: While reset is asserted, `busy_o`, `done_o`, `err_o` and `rdata_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| isp_en_i | input | 1 | Programming mode enabled |
| exec_i | input | 1 | Start pulse standing in for the programming window |
| ctrl_i | input | 8 | Control byte: bank, strobes, operation code |
| addr_hi_i | input | 8 | Target address, high byte |
| addr_lo_i | input | 8 | Target address, low byte |
| wdata_i | input | 8 | Program data |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last accepted command was illegal |
| rdata_o | output | 8 | Byte returned by the last read |

## Verification
The bench builds the block with MAIN_AW=8, LDR_AW=5, PROG_CYC=3 and ERASE_EXTRA=6. This makes a whole-bank erase short enough to repeat often, and the 32-entry loader bank can be read back in full. Random 16-bit addresses then alias constantly in both banks, which exercises the ignored upper address bits. The ratio of erase to program duration stays large enough that the two busy lengths cannot be confused.

// File: rtl/isp_pkg.sv
package isp_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2,
    OP_BAD   = 2'd3
  } isp_op_e;

  localparam logic [3:0] CODE_READ  = 4'b0000;
  localparam logic [3:0] CODE_PROG  = 4'b0001;
  localparam logic [3:0] CODE_ERASE = 4'b0010;

  // {output enable, chip enable} pairs that qualify each code
  localparam logic [1:0] STB_WRITE = 2'b10;
  localparam logic [1:0] STB_READ  = 2'b00;

  typedef struct packed {
    isp_op_e     op;
    logic        bank;
    logic [15:0] addr;
    logic [7:0]  data;
  } isp_cmd_t;

endpackage

// File: rtl/isp_cmd_decode.sv
module isp_cmd_decode
  import isp_pkg::*;
(
  input  logic [7:0] ctrl_i,
  input  logic [7:0] addr_hi_i,
  input  logic [7:0] addr_lo_i,
  input  logic [7:0] wdata_i,
  output isp_cmd_t   cmd_o
);

  logic [3:0] code;
  logic [1:0] stb;
  logic       unused_rsvd;

  assign code        = ctrl_i[3:0];
  assign stb         = ctrl_i[5:4];
  assign unused_rsvd = ctrl_i[7];

  always_comb begin
    cmd_o.bank = ctrl_i[6];
    cmd_o.addr = {addr_hi_i, addr_lo_i};
    cmd_o.data = wdata_i;
    if (code == CODE_ERASE && stb == STB_WRITE)     cmd_o.op = OP_ERASE;
    else if (code == CODE_PROG && stb == STB_WRITE) cmd_o.op = OP_PROG;
    else if (code == CODE_READ && stb == STB_READ)  cmd_o.op = OP_READ;
    else                                            cmd_o.op = OP_BAD;
  end

endmodule

// File: rtl/isp_seq.sv
module isp_seq
  import isp_pkg::*;
#(
  parameter int PROG_CYC  = 4,
  parameter int ERASE_CYC = 16
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     exec_i,
  input  logic     isp_en_i,
  input  isp_cmd_t cmd_i,
  output logic     busy_o,
  output logic     done_o,
  output logic     err_o,
  output logic     fire_o,
  output isp_cmd_t cmd_o
);

  localparam int CW = $clog2(ERASE_CYC + 1);

  logic          busy_q, done_q, err_q;
  logic [CW-1:0] cnt_q;
  isp_cmd_t      cmd_q;
  logic          accept;

  assign accept = exec_i & isp_en_i & ~busy_q;
  assign fire_o = busy_q & (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      cnt_q  <= '0;
      cmd_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        if (cmd_i.op == OP_BAD) begin
          err_q <= 1'b1;
        end else begin
          err_q  <= 1'b0;
          busy_q <= 1'b1;
          cmd_q  <= cmd_i;
          cnt_q  <= (cmd_i.op == OP_ERASE) ? CW'(ERASE_CYC - 1) : CW'(PROG_CYC - 1);
        end
      end else if (busy_q) begin
        if (cnt_q == '0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign err_o  = err_q;
  assign cmd_o  = cmd_q;

endmodule

// File: rtl/isp_bank.sv
module isp_bank #(
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          erase_i,
  input  logic          prog_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o
);

  localparam int DEPTH = 1 << AW;

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (erase_i) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
    end else if (prog_i) begin
      mem_q[addr_i] <= mem_q[addr_i] & wdata_i;
    end
  end

  assign rdata_o = mem_q[addr_i];

endmodule

// File: rtl/isp_cmd_engine.sv
module isp_cmd_engine
  import isp_pkg::*;
#(
  parameter int MAIN_AW     = 10,
  parameter int LDR_AW      = 6,
  parameter int PROG_CYC    = 4,
  parameter int ERASE_EXTRA = 12
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       isp_en_i,
  input  logic       exec_i,
  input  logic [7:0] ctrl_i,
  input  logic [7:0] addr_hi_i,
  input  logic [7:0] addr_lo_i,
  input  logic [7:0] wdata_i,
  output logic       busy_o,
  output logic       done_o,
  output logic       err_o,
  output logic [7:0] rdata_o
);

  localparam int ERASE_CYC = PROG_CYC + ERASE_EXTRA;

  initial begin
    if (MAIN_AW < 1 || MAIN_AW > 16) $error("MAIN_AW out of range");
    if (LDR_AW < 1 || LDR_AW > 12)   $error("LDR_AW out of range");
    if (PROG_CYC < 1 || ERASE_EXTRA < 1) $error("cycle counts must be positive");
  end

  isp_cmd_t   dec_cmd, cur_cmd;
  logic       fire;
  logic [7:0] bank_rd [2];
  logic [7:0] rdata_q;
  logic       unused_addr;

  assign unused_addr = ^cur_cmd.addr;

  isp_cmd_decode u_dec (
    .ctrl_i    (ctrl_i),
    .addr_hi_i (addr_hi_i),
    .addr_lo_i (addr_lo_i),
    .wdata_i   (wdata_i),
    .cmd_o     (dec_cmd)
  );

  isp_seq #(
    .PROG_CYC  (PROG_CYC),
    .ERASE_CYC (ERASE_CYC)
  ) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .exec_i   (exec_i),
    .isp_en_i (isp_en_i),
    .cmd_i    (dec_cmd),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .err_o    (err_o),
    .fire_o   (fire),
    .cmd_o    (cur_cmd)
  );

  for (genvar g = 0; g < 2; g++) begin : g_bank
    localparam int AW = (g == 0) ? MAIN_AW : LDR_AW;
    logic hit;
    assign hit = fire & (cur_cmd.bank == 1'(g));
    isp_bank #(.AW(AW)) u_bank (
      .clk_i   (clk_i),
      .erase_i (hit & (cur_cmd.op == OP_ERASE)),
      .prog_i  (hit & (cur_cmd.op == OP_PROG)),
      .addr_i  (cur_cmd.addr[AW-1:0]),
      .wdata_i (cur_cmd.data),
      .rdata_o (bank_rd[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             rdata_q <= 8'h00;
    else if (fire && cur_cmd.op == OP_READ)  rdata_q <= bank_rd[cur_cmd.bank];
  end

  assign rdata_o = rdata_q;

endmodule

// File: rtl/isp_cmd_engine_chk.sv
module isp_cmd_engine_chk #(
  parameter int PROG_CYC  = 4,
  parameter int ERASE_CYC = 16
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       isp_en_i,
  input logic       exec_i,
  input logic [7:0] ctrl_i,
  input logic       busy_o,
  input logic       done_o,
  input logic       err_o
);

  logic legal, accept, unused_ctrl;
  logic [15:0] blen_q;

  assign unused_ctrl = ctrl_i[7] ^ ctrl_i[6];
  assign legal  = (ctrl_i[5:4] == 2'b10 && (ctrl_i[3:0] == 4'b0010 || ctrl_i[3:0] == 4'b0001)) ||
                  (ctrl_i[5:4] == 2'b00 && ctrl_i[3:0] == 4'b0000);
  assign accept = exec_i && isp_en_i && !busy_o;

  // R6: illegal command flags error, never starts
  p_bad_err_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && !legal |=> err_o && !busy_o);

  // R7: disabled start is ignored
  p_dis_ignored_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_i && !isp_en_i && !busy_o |=> !busy_o && $stable(err_o));

  // R8: legal start raises busy
  p_start_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && legal |=> busy_o && !err_o);

  // R8: done follows the fall of busy, one cycle wide
  p_done_fall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $fell(busy_o));
  p_fall_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R9: busy and error only move at accepted starts or completions
  p_busy_err_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(err_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blen_q <= '0;
    end else begin
      if (busy_o) blen_q <= blen_q + 16'd1;
      else        blen_q <= '0;
      if (!busy_o && blen_q != '0)
        p_busy_len_r8: assert (blen_q == 16'(PROG_CYC) || blen_q == 16'(ERASE_CYC))
          else $error("busy length %0d", blen_q);
    end
  end

endmodule

bind isp_cmd_engine isp_cmd_engine_chk #(
  .PROG_CYC  (PROG_CYC),
  .ERASE_CYC (PROG_CYC + ERASE_EXTRA)
) u_chk (.*);

// File: tb/isp_cmd_engine_tb.sv
module isp_cmd_engine_tb_top;

  localparam int CLK_PERIOD  = 10;
  localparam int MAIN_AW     = 8;
  localparam int LDR_AW      = 5;
  localparam int PROG_CYC    = 3;
  localparam int ERASE_EXTRA = 6;
  localparam int MAIN_N      = 1 << MAIN_AW;
  localparam int LDR_N       = 1 << LDR_AW;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic isp_en_i = 1'b0, exec_i = 1'b0;
  logic [7:0] ctrl_i = '0, addr_hi_i = '0, addr_lo_i = '0, wdata_i = '0;
  logic busy_o, done_o, err_o;
  logic [7:0] rdata_o;

  int checks = 0, errors = 0;
  logic exp_err = 1'b0;
  logic [7:0] m_main [MAIN_N];
  logic [7:0] m_ldr  [LDR_N];

  always #(CLK_PERIOD / 2) clk = ~clk;

  isp_cmd_engine #(
    .MAIN_AW(MAIN_AW), .LDR_AW(LDR_AW), .PROG_CYC(PROG_CYC), .ERASE_EXTRA(ERASE_EXTRA)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .isp_en_i(isp_en_i), .exec_i(exec_i),
    .ctrl_i(ctrl_i), .addr_hi_i(addr_hi_i), .addr_lo_i(addr_lo_i), .wdata_i(wdata_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .rdata_o(rdata_o)
  );

  // 0 read, 1 program, 2 erase, 3 illegal, straight from the requirement table
  function automatic int exp_op(input logic [7:0] c);
    if (c[3:0] == 4'h2 && c[5] && !c[4])  return 2;
    if (c[3:0] == 4'h1 && c[5] && !c[4])  return 1;
    if (c[3:0] == 4'h0 && !c[5] && !c[4]) return 0;
    return 3;
  endfunction

  function automatic logic [7:0] mk_ctrl(input int op, input logic bank, input logic rsv);
    case (op)
      0:       return {rsv, bank, 2'b00, 4'h0};
      1:       return {rsv, bank, 2'b10, 4'h1};
      default: return {rsv, bank, 2'b10, 4'h2};
    endcase
  endfunction

  function automatic logic [7:0] model_rd(input logic bank, input logic [15:0] a);
    if (bank) return m_ldr[a[LDR_AW-1:0]];
    return m_main[a[MAIN_AW-1:0]];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic model_apply(input int op, input logic bank, input logic [15:0] a, input logic [7:0] d);
    if (op == 2) begin
      if (bank) for (int i = 0; i < LDR_N; i++) m_ldr[i] = 8'hFF;
      else      for (int i = 0; i < MAIN_N; i++) m_main[i] = 8'hFF;
    end else if (op == 1) begin
      if (bank) m_ldr[a[LDR_AW-1:0]]   = m_ldr[a[LDR_AW-1:0]] & d;
      else      m_main[a[MAIN_AW-1:0]] = m_main[a[MAIN_AW-1:0]] & d;
    end
  endtask

  task automatic do_cmd(input logic [7:0] c, input logic [15:0] a, input logic [7:0] d,
                        input logic en, input string req);
    int op, n, dur;
    op = exp_op(c);
    @(negedge clk);
    ctrl_i = c; addr_hi_i = a[15:8]; addr_lo_i = a[7:0]; wdata_i = d;
    isp_en_i = en; exec_i = 1'b1;
    @(negedge clk);
    exec_i = 1'b0;
    if (!en) begin
      chk(busy_o == 1'b0, {req, " R7 busy"}, busy_o, 0);
      chk(err_o == exp_err, {req, " R7 err"}, err_o, exp_err);
    end else if (op == 3) begin
      exp_err = 1'b1;
      chk(busy_o == 1'b0 && err_o == 1'b1, {req, " R6 err/busy"}, {busy_o, err_o}, 2'b01);
    end else begin
      exp_err = 1'b0;
      dur = (op == 2) ? PROG_CYC + ERASE_EXTRA : PROG_CYC;
      n = 0;
      while (busy_o && n < 100) begin
        n++;
        @(negedge clk);
      end
      chk(n == dur, {req, " R8 busy len"}, n, dur);
      chk(done_o == 1'b1 && err_o == 1'b0, {req, " R8 done"}, {done_o, err_o}, 2'b10);
      if (op == 0) chk(rdata_o == model_rd(c[6], a), {req, " R4 rdata"}, rdata_o, model_rd(c[6], a));
      model_apply(op, c[6], a, d);
      @(negedge clk);
      chk(done_o == 1'b0, {req, " R8 done pulse"}, done_o, 0);
    end
  endtask

  task automatic rd_chk(input logic bank, input logic [15:0] a, input string req);
    do_cmd(mk_ctrl(0, bank, 1'b0), a, 8'h00, 1'b1, req);
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk({busy_o, done_o, err_o, rdata_o} == 11'd0, "R10 reset outputs", {busy_o, done_o, err_o, rdata_o}, 0);
    rst_ni = 1'b1;

    // R2: erase both banks, bit 7 set on one (R1)
    do_cmd(mk_ctrl(2, 1'b0, 1'b0), 16'h1234, 8'h00, 1'b1, "R2 erase main");
    do_cmd(mk_ctrl(2, 1'b1, 1'b1), 16'h0000, 8'h00, 1'b1, "R2 R1 erase ldr rsv");
    rd_chk(1'b0, 16'h00FF, "R2 main FF");
    rd_chk(1'b1, 16'h001F, "R2 ldr FF");

    // R3: AND accumulation
    do_cmd(mk_ctrl(1, 1'b0, 1'b0), 16'h0010, 8'hF0, 1'b1, "R3 prog1");
    do_cmd(mk_ctrl(1, 1'b0, 1'b0), 16'h0010, 8'h3C, 1'b1, "R3 prog2");
    rd_chk(1'b0, 16'h0010, "R3 and result");
    chk(rdata_o == 8'h30, "R3 literal", rdata_o, 8'h30);

    // R1: bank bit steers the write; other bank untouched
    do_cmd(mk_ctrl(1, 1'b1, 1'b0), 16'h0010, 8'h5A, 1'b1, "R1 prog ldr");
    rd_chk(1'b0, 16'h0010, "R1 main kept");
    rd_chk(1'b1, 16'h0010, "R1 ldr written");

    // R5: aliasing through ignored upper bits
    do_cmd(mk_ctrl(1, 1'b1, 1'b0), 16'hABE3, 8'h0F, 1'b1, "R5 ldr alias prog");
    rd_chk(1'b1, 16'h0003, "R5 ldr alias read");
    do_cmd(mk_ctrl(1, 1'b0, 1'b0), 16'h7F44, 8'h81, 1'b1, "R5 main alias prog");
    rd_chk(1'b0, 16'h0044, "R5 main alias read");

    // R2: erase of loader leaves main intact
    do_cmd(mk_ctrl(2, 1'b1, 1'b0), 16'h0000, 8'h00, 1'b1, "R2 erase ldr");
    rd_chk(1'b0, 16'h0044, "R2 main survives");
    rd_chk(1'b1, 16'h0003, "R2 ldr erased");

    // R6: illegal combinations, then clear by a legal command
    do_cmd(8'h32, 16'h0044, 8'h00, 1'b1, "R6 erase bad strobes");
    do_cmd(8'h03, 16'h0044, 8'h00, 1'b1, "R6 bad code");
    do_cmd(8'h20, 16'h0044, 8'h00, 1'b1, "R6 read with oe");
    rd_chk(1'b0, 16'h0044, "R6 no change");

    // R7: disabled program ignored
    do_cmd(8'h33, 16'h0000, 8'h00, 1'b1, "R6 set err");
    do_cmd(mk_ctrl(1, 1'b0, 1'b0), 16'h0044, 8'h00, 1'b0, "R7 disabled prog");
    do_cmd(mk_ctrl(2, 1'b0, 1'b0), 16'h0044, 8'h00, 1'b0, "R7 disabled erase");
    rd_chk(1'b0, 16'h0044, "R7 main unchanged");

    // R9: start pulse during erase is dropped
    @(negedge clk);
    ctrl_i = mk_ctrl(2, 1'b1, 1'b0); isp_en_i = 1'b1; exec_i = 1'b1;
    @(negedge clk);
    exec_i = 1'b0;
    model_apply(2, 1'b1, 16'h0, 8'h0);
    @(negedge clk);
    ctrl_i = mk_ctrl(1, 1'b1, 1'b0); addr_hi_i = 8'h00; addr_lo_i = 8'h07; wdata_i = 8'h00; exec_i = 1'b1;
    @(negedge clk);
    exec_i = 1'b0;
    for (int i = 0; i < 50 && busy_o; i++) @(negedge clk);
    @(negedge clk);
    chk(busy_o == 1'b0, "R9 no restart", busy_o, 0);
    rd_chk(1'b1, 16'h0007, "R9 ldr byte untouched");

    // random mix
    for (int k = 0; k < 300; k++) begin
      int r, op;
      logic bank, rsv, en;
      logic [7:0] c;
      r = $urandom % 20; bank = 1'($urandom); rsv = 1'($urandom); en = 1'b1;
      if (r == 0)      op = 2;
      else if (r < 8)  op = 1;
      else if (r < 15) op = 0;
      else             op = 3;
      if (op == 3) c = 8'($urandom);
      else         c = mk_ctrl(op, bank, rsv);
      if (r == 19) en = 1'b0;
      do_cmd(c, 16'($urandom), 8'($urandom), en, "R1 R3 R4 R5 random");
    end

    for (int i = 0; i < LDR_N; i++) rd_chk(1'b1, 16'(i), "R4 ldr sweep");
    for (int i = 0; i < MAIN_N; i += 4) rd_chk(1'b0, 16'(i), "R4 main sweep");

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule